// File: doc/BRIEF.md
# Dual-Source Carrier Tracking Loop with Lock-Gated Handover

This block removes a residual carrier from a stream of complex baseband samples. A phase-accumulator oscillator supplies a phase for every incoming sample. A sine/cosine table turns that phase into a unit phasor, and a complex multiply rotates the sample back by that angle. The de-rotated samples go on to a matched filter and to an acquisition arm, both outside this block.

A proportional-plus-integral filter sets the oscillator frequency. The filter takes its error from one of two external discriminators:

- a non-data-aided acquisition error, delivered with every sample;
- a decision-directed error, delivered once per symbol with a strobe.

The loop starts on the acquisition error. A lock detector watches an external lock metric. When handover is enabled, control moves to the decision-directed error once the loop is locked and symbol timing reports settled. The integrator, the commanded frequency and the oscillator phase all carry across the switch untouched. Only the error source changes.

Both discriminators and the symbol timing recovery sit outside this block. It sees only their outputs.

Top module: `carrier_handover_loop`

## Requirements
- R1: Each sample accepted with `s_valid` produces exactly one output with `o_valid` two clock edges later. The output is `o_i + j·o_q = (s_i + j·s_q)·e^(−jθ)·(2^15−1)/2^15`, with θ = 2π·phase[31:22]/1024 (default widths). The result is rounded toward minus infinity.
- R2: The 32-bit phase is 0 after reset. Each sample uses the current phase. The phase then advances by `nco_freq` once per accepted sample and never on any other cycle.
- R3: While `rst` is high: `nco_freq` equals `seed_freq`, and `locked`, `dd_mode` and `o_valid` are all 0.
- R4: A loop update with signed error e works as follows. The integrator becomes integ + (e <<< `ki_shift`). On the next edge, `nco_freq` becomes `seed_freq` + new integ + (e <<< `kp_shift`), taken modulo 2^32. The integrator is 0 after reset.
- R5: With `dd_mode` at 0, the loop updates on every cycle that has `s_valid`, using `acq_err`. A cycle without `s_valid` leaves `nco_freq` unchanged.
- R6: A valid sample with `lock_metric` > `lock_thresh` (both signed) extends a run of consecutive such samples, which saturates at its maximum. Any other valid sample clears the run. `locked` goes to 1 on the edge where the run reaches `lock_need`, and to 0 on the edge of a valid sample that is not above the threshold.
- R7: `dd_mode` goes to 1 on an edge where `handover_en`, `locked` and `timing_ok` are all 1. It then stays at 1 while `handover_en` stays high. It goes to 0 on the edge after `handover_en` is low. With `handover_en` at 0 it never becomes 1.
- R8: With `dd_mode` at 1, the loop updates only on `dd_strobe` cycles, using `dd_err`. That error is Im(y·conj(â))/|y|, where y is the recovered symbol and â is the nearest constellation point, given as a signed fraction. `acq_err` and `s_valid` have no effect on `nco_freq` in this mode.
- R9: Switching into or out of `dd_mode` leaves the integrator, `nco_freq` and the phase unchanged. The first update after the switch starts from the integrator value built up before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample present |
| s_i | input | DW | In-phase sample, signed |
| s_q | input | DW | Quadrature sample, signed |
| acq_err | input | EW | Acquisition phase error, signed, valid with `s_valid` |
| dd_strobe | input | 1 | Decision-directed error present |
| dd_err | input | EW | Decision-directed phase error, signed |
| lock_metric | input | EW | Lock metric, signed, valid with `s_valid` |
| lock_thresh | input | EW | Lock threshold, signed |
| lock_need | input | CW | Consecutive above-threshold samples required for lock |
| timing_ok | input | 1 | Symbol timing settled |
| handover_en | input | 1 | Allow the switch to the decision-directed error |
| seed_freq | input | PHW | Initial frequency word (phase step per sample) |
| kp_shift | input | SW | Proportional gain as a left shift |
| ki_shift | input | SW | Integral gain as a left shift |
| o_valid | output | 1 | De-rotated sample present |
| o_i | output | DW+1 | De-rotated in-phase sample |
| o_q | output | DW+1 | De-rotated quadrature sample |
| nco_freq | output | PHW | Current frequency word |
| locked | output | 1 | Lock indicator |
| dd_mode | output | 1 | 1 when the decision-directed error drives the loop |

## Verification
**De-rotation.** The rotator is driven at a quarter-cycle step so that the phase visits 0°, 90°, 180° and 270° in turn. Each angle exposes a different pairing and sign of the four products, so a swapped sine/cosine or a wrong conjugate shows up as a mismatched output component.

**Loop filter.** Runs of constant positive and negative acquisition error separate the proportional term from the accumulated integral term.

**Lock detector.** Runs of lock metric that fall one short of the count, that sit exactly at the threshold, and that reach the count pin down the strict comparison and the consecutive-run rule.

**Handover.** The handover sequence first holds `timing_ok` low while lock is present. It then applies a large acquisition error with no symbol strobe, and finally a single strobe. This shows the gate, the change of error source, and that the integrator carries across the switch.

// File: rtl/carrier_loop_pkg.sv
package carrier_loop_pkg;
  // Which error stream is allowed to steer the loop filter.
  typedef enum logic {
    SRC_ACQ = 1'b0,
    SRC_DD  = 1'b1
  } err_src_e;
endpackage

// File: rtl/cl_sincos_rom.sv
// Full-wave cosine/sine table with a registered read, suitable for block RAM.
module cl_sincos_rom #(
  parameter int AW = 10,
  parameter int RW = 16
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic [AW-1:0]        addr,
  output logic signed [RW-1:0] cos_o,
  output logic signed [RW-1:0] sin_o
);
  localparam int  DEPTH  = 1 << AW;
  localparam real AMP    = real'((1 << (RW - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [RW-1:0] cos_mem [DEPTH];
  logic signed [RW-1:0] sin_mem [DEPTH];

  // Round to nearest, away from zero on ties.
  function automatic logic signed [RW-1:0] quant(input real x);
    real r;
    r = x * AMP;
    r = (r >= 0.0) ? r + 0.5 : r - 0.5;
    return RW'($rtoi(r));
  endfunction

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      cos_mem[k] = quant($cos(TWO_PI * real'(k) / real'(DEPTH)));
      sin_mem[k] = quant($sin(TWO_PI * real'(k) / real'(DEPTH)));
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      cos_o <= cos_mem[addr];
      sin_o <= sin_mem[addr];
    end
  end
endmodule

// File: rtl/cl_nco.sv
// Phase accumulator feeding the table; one step per accepted sample.
module cl_nco #(
  parameter int PHW = 32,
  parameter int AW  = 10,
  parameter int RW  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [PHW-1:0]       freq,
  output logic signed [RW-1:0] cos_o,
  output logic signed [RW-1:0] sin_o
);
  logic [PHW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + freq;
  end

  cl_sincos_rom #(.AW(AW), .RW(RW)) u_rom (
    .clk   (clk),
    .en    (adv),
    .addr  (phase[PHW-1 -: AW]),
    .cos_o (cos_o),
    .sin_o (sin_o)
  );
endmodule

// File: rtl/cl_mixer.sv
// Complex multiply by the conjugate phasor; two-stage registered path.
module cl_mixer #(
  parameter int DW = 16,
  parameter int RW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  input  logic signed [RW-1:0] cos_i,
  input  logic signed [RW-1:0] sin_i,
  output logic                 o_valid,
  output logic signed [DW:0]   o_i,
  output logic signed [DW:0]   o_q
);
  localparam int PW = DW + RW;
  localparam int AW = PW + 1;

  logic                 v1;
  logic signed [DW-1:0] xi, xq;
  logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [AW-1:0] acc_i, acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      xi <= '0;
      xq <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        xi <= s_i;
        xq <= s_q;
      end
    end
  end

  always_comb begin
    p_ic  = xi * cos_i;
    p_qs  = xq * sin_i;
    p_qc  = xq * cos_i;
    p_is  = xi * sin_i;
    acc_i = AW'(p_ic) + AW'(p_qs);
    acc_q = AW'(p_qc) - AW'(p_is);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_i     <= '0;
      o_q     <= '0;
    end else begin
      o_valid <= v1;
      if (v1) begin
        o_i <= (DW+1)'(acc_i >>> (RW - 1));
        o_q <= (DW+1)'(acc_q >>> (RW - 1));
      end
    end
  end
endmodule

// File: rtl/cl_loop_filter.sv
// Type-2 proportional-plus-integral filter producing the frequency word.
module cl_loop_filter #(
  parameter int PHW = 32,
  parameter int EW  = 16,
  parameter int SW  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [EW-1:0] err,
  input  logic [SW-1:0]        kp_sh,
  input  logic [SW-1:0]        ki_sh,
  input  logic [PHW-1:0]       seed,
  output logic [PHW-1:0]       freq_o
);
  logic signed [PHW-1:0] integ, err_x, p_term, i_term, integ_nx;

  always_comb begin
    err_x    = {{(PHW-EW){err[EW-1]}}, err};
    p_term   = err_x <<< kp_sh;
    i_term   = err_x <<< ki_sh;
    integ_nx = integ + i_term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ  <= '0;
      freq_o <= seed;
    end else if (upd) begin
      integ  <= integ_nx;
      freq_o <= seed + $unsigned(integ_nx) + $unsigned(p_term);
    end
  end
endmodule

// File: rtl/cl_lock_ctrl.sv
// Consecutive-run lock detector and error-source selection.
module cl_lock_ctrl
  import carrier_loop_pkg::*;
#(
  parameter int EW = 16,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic signed [EW-1:0] metric,
  input  logic signed [EW-1:0] thresh,
  input  logic [CW-1:0]        need,
  input  logic                 timing_ok,
  input  logic                 ho_en,
  output logic                 locked,
  output err_src_e             src
);
  logic [CW-1:0] run, run_nx;
  logic          above;

  always_comb begin
    above  = metric > thresh;
    run_nx = (run == '1) ? run : run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      locked <= 1'b0;
      src    <= SRC_ACQ;
    end else begin
      if (s_valid) begin
        if (above) begin
          run    <= run_nx;
          locked <= (run_nx >= need);
        end else begin
          run    <= '0;
          locked <= 1'b0;
        end
      end
      if (!ho_en)                  src <= SRC_ACQ;
      else if (locked && timing_ok) src <= SRC_DD;
    end
  end
endmodule

// File: rtl/carrier_handover_loop.sv
module carrier_handover_loop
  import carrier_loop_pkg::*;
#(
  parameter int DW  = 16,
  parameter int EW  = 16,
  parameter int PHW = 32,
  parameter int AW  = 10,
  parameter int RW  = 16,
  parameter int CW  = 8,
  parameter int SW  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  input  logic signed [EW-1:0] acq_err,
  input  logic                 dd_strobe,
  input  logic signed [EW-1:0] dd_err,
  input  logic signed [EW-1:0] lock_metric,
  input  logic signed [EW-1:0] lock_thresh,
  input  logic [CW-1:0]        lock_need,
  input  logic                 timing_ok,
  input  logic                 handover_en,
  input  logic [PHW-1:0]       seed_freq,
  input  logic [SW-1:0]        kp_shift,
  input  logic [SW-1:0]        ki_shift,
  output logic                 o_valid,
  output logic signed [DW:0]   o_i,
  output logic signed [DW:0]   o_q,
  output logic [PHW-1:0]       nco_freq,
  output logic                 locked,
  output logic                 dd_mode
);
  err_src_e             src;
  logic                 upd;
  logic signed [EW-1:0] sel_err;
  logic signed [RW-1:0] cos_w, sin_w;

  always_comb begin
    dd_mode = (src == SRC_DD);
    upd     = dd_mode ? dd_strobe : s_valid;
    sel_err = dd_mode ? dd_err : acq_err;
  end

  cl_lock_ctrl #(.EW(EW), .CW(CW)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .metric    (lock_metric),
    .thresh    (lock_thresh),
    .need      (lock_need),
    .timing_ok (timing_ok),
    .ho_en     (handover_en),
    .locked    (locked),
    .src       (src)
  );

  cl_loop_filter #(.PHW(PHW), .EW(EW), .SW(SW)) u_lf (
    .clk    (clk),
    .rst    (rst),
    .upd    (upd),
    .err    (sel_err),
    .kp_sh  (kp_shift),
    .ki_sh  (ki_shift),
    .seed   (seed_freq),
    .freq_o (nco_freq)
  );

  cl_nco #(.PHW(PHW), .AW(AW), .RW(RW)) u_nco (
    .clk   (clk),
    .rst   (rst),
    .adv   (s_valid),
    .freq  (nco_freq),
    .cos_o (cos_w),
    .sin_o (sin_w)
  );

  cl_mixer #(.DW(DW), .RW(RW)) u_mix (
    .clk      (clk),
    .rst      (rst),
    .in_valid (s_valid),
    .s_i      (s_i),
    .s_q      (s_q),
    .cos_i    (cos_w),
    .sin_i    (sin_w),
    .o_valid  (o_valid),
    .o_i      (o_i),
    .o_q      (o_q)
  );
endmodule

// File: rtl/carrier_handover_loop_chk.sv
module carrier_handover_loop_chk #(
  parameter int DW  = 16,
  parameter int EW  = 16,
  parameter int PHW = 32,
  parameter int CW  = 8,
  parameter int SW  = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 s_valid,
  input logic                 dd_strobe,
  input logic signed [EW-1:0] lock_metric,
  input logic signed [EW-1:0] lock_thresh,
  input logic                 timing_ok,
  input logic                 handover_en,
  input logic                 o_valid,
  input logic [PHW-1:0]       nco_freq,
  input logic                 locked,
  input logic                 dd_mode
);
  // R1: every accepted sample emerges two edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    s_valid |=> ##1 o_valid);

  // R5: acquisition mode holds the frequency when no sample arrives
  a_r5_acq_hold: assert property (@(posedge clk) disable iff (rst)
    (!dd_mode && !s_valid) |=> $stable(nco_freq));

  // R8: decision-directed mode holds the frequency between strobes
  a_r8_dd_hold: assert property (@(posedge clk) disable iff (rst)
    (dd_mode && !dd_strobe) |=> $stable(nco_freq));

  // R7: the switch requires lock, settled timing and the enable
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(dd_mode) |-> $past(locked && timing_ok && handover_en));

  // R7: handover disabled forces the acquisition source
  a_r7_disable: assert property (@(posedge clk) disable iff (rst)
    !handover_en |=> !dd_mode);

  // R6: a valid sample not above threshold drops the lock indicator
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (s_valid && (lock_metric <= lock_thresh)) |=> !locked);
endmodule

bind carrier_handover_loop carrier_handover_loop_chk #(
  .DW(DW), .EW(EW), .PHW(PHW), .CW(CW), .SW(SW)
) u_chk (.*);

// File: tb/sim_carrier_handover_loop.sv
`timescale 1ns/1ps
module sim_carrier_handover_loop;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               s_valid = 1'b0;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic signed [15:0] acq_err = '0, dd_err = '0;
  logic               dd_strobe = 1'b0;
  logic signed [15:0] lock_metric = '0, lock_thresh = '0;
  logic [7:0]         lock_need = 8'd1;
  logic               timing_ok = 1'b0, handover_en = 1'b0;
  logic [31:0]        seed_freq = 32'h4000_0000;
  logic [4:0]         kp_shift = '0, ki_shift = '0;
  logic               o_valid, locked, dd_mode;
  logic signed [16:0] o_i, o_q;
  logic [31:0]        nco_freq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  carrier_handover_loop u0 (.*);

  // {in_i, in_q, exp_i, exp_q}; phase steps 90 degrees per sample from 0
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{  1000,   200,  1000,   200},
    '{  1000,   200,   200, -1000},
    '{  -300,   500,   300,  -500},
    '{   400,  -700,   700,   400},
    '{ -1234,     0, -1234,     0},
    '{     0,  3000,  3000,     0},
    '{  2000, -2000, -2000,  2000},
    '{   -50,    60,   -60,   -50}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_tol(input string req, input longint act, input longint exp);
    longint d;
    total++;
    d = act - exp;
    if (d > 2 || d < -2) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic one_sample(input int m);
    @(negedge clk);
    s_valid = 1'b1;
    lock_metric = 16'(m);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    // R3: reset state
    repeat (2) @(negedge clk);
    chk("R3 nco_freq", nco_freq, 32'h4000_0000);
    chk("R3 locked", locked, 0);
    chk("R3 dd_mode", dd_mode, 0);
    chk("R3 o_valid", o_valid, 0);
    rst = 1'b0;

    // R1/R2: de-rotation at 0/90/180/270 degrees, phase from 0
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_i = 16'(VEC[k][0]);
      s_q = 16'(VEC[k][1]);
      @(negedge clk);
      s_valid = 1'b0;
      @(negedge clk);
      chk("R1 o_valid", o_valid, 1);
      chk_tol("R1/R2 o_i", o_i, VEC[k][2]);
      chk_tol("R1/R2 o_q", o_q, VEC[k][3]);
    end
    @(negedge clk);
    chk("R1 o_valid low when idle", o_valid, 0);
    chk("R5 zero error keeps seed", nco_freq, 32'h4000_0000);

    // R6: lock run rule, strict threshold
    lock_thresh = 16'sd100;
    lock_need = 8'd4;
    do_reset();
    for (int k = 0; k < 3; k++) one_sample(150);
    chk("R6 three of four", locked, 0);
    one_sample(100);
    chk("R6 equal is not above", locked, 0);
    for (int k = 0; k < 3; k++) one_sample(150);
    chk("R6 run restarted", locked, 0);
    one_sample(150);
    chk("R6 fourth sets lock", locked, 1);
    one_sample(50);
    chk("R6 below clears lock", locked, 0);

    // R4/R5: loop filter in acquisition mode
    s = 32'h0100_0000;
    seed_freq = s;
    kp_shift = 5'd4;
    ki_shift = 5'd2;
    lock_thresh = 16'sd0;
    lock_need = 8'd2;
    lock_metric = 16'sd50;
    do_reset();
    acq_err = 16'sd10;
    @(negedge clk);
    s_valid = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R4 acq update", nco_freq, s + 32'(40 * k) + 32'd160);
    end
    s_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 idle hold", nco_freq, s + 32'd280);
    chk("R6 locked after run", locked, 1);
    acq_err = -16'sd5;
    one_sample(50);
    chk("R4 negative error", nco_freq, s + 32'd20);

    // R7: gate on timing
    handover_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no switch without timing", dd_mode, 0);
    timing_ok = 1'b1;
    @(negedge clk);
    chk("R7 switch on lock and timing", dd_mode, 1);
    chk("R9 freq continuous at switch", nco_freq, s + 32'd20);

    // R8: acquisition error ignored in decision-directed mode
    acq_err = 16'sd1000;
    s_valid = 1'b1;
    repeat (2) @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    chk("R8 acq_err ignored", nco_freq, s + 32'd20);
    dd_err = 16'sd3;
    dd_strobe = 1'b1;
    @(negedge clk);
    dd_strobe = 1'b0;
    chk("R8/R9 strobe update uses carried integ", nco_freq, s + 32'd160);
    repeat (2) @(negedge clk);
    chk("R8 hold between strobes", nco_freq, s + 32'd160);

    // R7/R9: back to acquisition keeps the integrator
    handover_en = 1'b0;
    @(negedge clk);
    chk("R7 disable returns to acq", dd_mode, 0);
    acq_err = 16'sd0;
    one_sample(50);
    chk("R9 integ kept after return", nco_freq, s + 32'd112);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule